// File: doc/BRIEF.md
# PFC Protection and Start-up Supervisor

This block is the sequencing brain of a boost power-factor stage. It never sees an analog level itself: external comparators hand it one-bit flags for the supply thresholds, for the bulk-voltage sense pin (open-loop floor, near-regulation level, first over-voltage trip and release) and for an independent second over-voltage pin (trip and release). From these flags it decides whether the power switch may run, whether the loop is still in soft-start, whether the stage is parked in standby, and it reports the most urgent active condition as a small code.

The two over-voltage paths are filtered by their own blanking counters, so a trip flag must hold for an unbroken run of clock cycles before it counts. The first path only gates the switch and lets it resume directly on release. The second path, on release, pushes the machine back into soft-start. A peak-current event stretches the gate-off request for a fixed number of cycles without disturbing any state.

Top module: `pfc_supervisor`

## Requirements
- R1: After reset the machine sits in the supply-off state (fault_code 1, run_en 0, gate_off 1). It stays there while vcc_above_on is low, and once it has left that state it stays out while vcc_below_off is low, even after vcc_above_on drops (hysteresis).
- R2: From the supply-off state, vcc_above_on with fb_ok high enters soft-start (soft_start 1, run_en 1, gate_off 0, fault_code 0); with fb_ok low it enters standby (standby 1, fault_code 2).
- R3: While running or in soft-start, fb_ok low moves the machine to standby (run_en 0, gate_off 1, fault_code 2); fb_ok high again restarts through soft-start.
- R4: In soft-start, fb_near high releases soft-start (soft_start 0) while run_en stays 1.
- R5: The first over-voltage path trips only after ov1_set has been sampled high on OV1_BLANK_CYC consecutive edges; a single low sample restarts the count.
- R6: A tripped first over-voltage path forces gate_off 1 and run_en 0 with fault_code 5; ov1_clr high releases it on the next edge and switching resumes with soft_start unchanged at 0.
- R7: The second over-voltage path trips after OV2_BLANK_CYC consecutive high samples of ov2_set (fault_code 4, gate_off 1); its release by ov2_clr returns the machine to soft-start (soft_start 1).
- R8: With both paths tripped fault_code is 3 and gate_off stays 1 until both have been released, in either order.
- R9: A sample of pcl_in high holds gate_off at 1 for PCL_HOLD_CYC cycles counted from the last high sample, and changes neither run_en, soft_start nor fault_code.
- R10: vcc_below_off high returns the machine to the supply-off state from any state on the next edge and clears both over-voltage trips.
- R11: fault_code reports the highest-priority condition: 1 supply off, then 2 open loop/standby, then 3 both over-voltages, then 4 second over-voltage, then 5 first over-voltage, otherwise 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vcc_above_on | input | 1 | Supply is above its turn-on level |
| vcc_below_off | input | 1 | Supply is below its turn-off level |
| fb_ok | input | 1 | Sense pin above the open-loop floor |
| fb_near | input | 1 | Output at or above the near-regulation level |
| ov1_set | input | 1 | Sense pin above the first over-voltage trip level |
| ov1_clr | input | 1 | Sense pin below the first over-voltage release level |
| ov2_set | input | 1 | Second over-voltage pin above its trip level |
| ov2_clr | input | 1 | Second over-voltage pin below its release level |
| pcl_in | input | 1 | Peak-current-limit comparator flag |
| run_en | output | 1 | Power stage may switch |
| soft_start | output | 1 | Soft-start ramp active |
| standby | output | 1 | Parked on low sense voltage |
| gate_off | output | 1 | Request to hold the gate off |
| fault_code | output | 3 | Highest-priority active condition |

## Verification
Every state change lands one edge after the flags that cause it are sampled, so the bench drives on the falling edge and compares on the following falling edge. Blanking is swept over hold lengths from one to one past the blanking count, with the trip expected after exactly the blanking count of edges and a release one edge after the clear flag. The peak-current stretch is walked sample by sample: gate_off is expected high for the hold count of compares after the last high sample and low on the next.

// File: rtl/pfc_sup_pkg.sv
// Shared types of the PFC supervisor: state encoding and fault codes.
package pfc_sup_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_STBY = 2'd1,
        ST_SOFT = 2'd2,
        ST_RUN  = 2'd3
    } sup_state_t;

    typedef enum logic [2:0] {
        FC_NONE    = 3'd0,
        FC_UVLO    = 3'd1,
        FC_OPEN    = 3'd2,
        FC_OV_BOTH = 3'd3,
        FC_OV2     = 3'd4,
        FC_OV1     = 3'd5
    } fault_code_t;
endpackage

// File: rtl/ov_blanker.sv
// Blanking filter for one over-voltage path.
// Trips once set_i has been sampled high on BLANK consecutive edges; any
// low sample restarts the count. Once tripped it holds until clr_i.
// Assumes set_i and clr_i are already synchronous flags. kill clears it.
module ov_blanker #(
    parameter int BLANK = 1200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kill,
    input  logic set_i,
    input  logic clr_i,
    output logic trip_o,
    output logic release_o
);
    localparam int CW = (BLANK < 2) ? 1 : $clog2(BLANK + 1);
    localparam logic [CW-1:0] LAST = CW'(BLANK - 1);

    logic [CW-1:0] cnt;

    // Count consecutive trip samples, latch the trip, release on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            cnt    <= '0;
            trip_o <= 1'b0;
        end else if (trip_o) begin
            cnt <= '0;
            if (clr_i) trip_o <= 1'b0;
        end else if (!set_i) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt    <= '0;
            trip_o <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Release happens on the edge where a tripped path sees its clear flag.
    assign release_o = trip_o & clr_i;
endmodule

// File: rtl/pcl_stretch.sv
// Peak-current pulse stretcher: after each high sample of pcl_i the
// active output stays high for HOLD cycles. Holds no supervisor state.
module pcl_stretch #(
    parameter int HOLD = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pcl_i,
    output logic active_o
);
    localparam int HW = $clog2(HOLD + 1);
    localparam logic [HW-1:0] LOAD = HW'(HOLD);

    logic [HW-1:0] cnt;

    // Reload on every event sample, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (pcl_i)       cnt <= LOAD;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign active_o = (cnt != '0);
endmodule

// File: rtl/pfc_supervisor.sv
// PFC start-up and protection supervisor (top).
// Sequences supply-off, standby, soft-start and run from comparator flags,
// filters two over-voltage paths with separate blanking and recovery rules,
// stretches peak-current events into a gate-off request and reports a
// priority-encoded fault code. All outputs follow the sampled flags by one
// edge. Assumes all flag inputs are synchronous to clk.
module pfc_supervisor
    import pfc_sup_pkg::*;
#(
    parameter int OV1_BLANK_CYC = 1200,
    parameter int OV2_BLANK_CYC = 1200,
    parameter int PCL_HOLD_CYC  = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vcc_above_on,
    input  logic       vcc_below_off,
    input  logic       fb_ok,
    input  logic       fb_near,
    input  logic       ov1_set,
    input  logic       ov1_clr,
    input  logic       ov2_set,
    input  logic       ov2_clr,
    input  logic       pcl_in,
    output logic       run_en,
    output logic       soft_start,
    output logic       standby,
    output logic       gate_off,
    output logic [2:0] fault_code
);
    sup_state_t  state_q, state_d;
    fault_code_t code;
    logic        ov1_trip, ov2_trip, ov1_release, ov2_release;
    logic        pcl_active, in_off;

    assign in_off = (state_q == ST_OFF);

    ov_blanker #(.BLANK(OV1_BLANK_CYC)) u_ov1 (
        .clk(clk), .rst_n(rst_n), .kill(in_off),
        .set_i(ov1_set), .clr_i(ov1_clr),
        .trip_o(ov1_trip), .release_o(ov1_release)
    );

    ov_blanker #(.BLANK(OV2_BLANK_CYC)) u_ov2 (
        .clk(clk), .rst_n(rst_n), .kill(in_off),
        .set_i(ov2_set), .clr_i(ov2_clr),
        .trip_o(ov2_trip), .release_o(ov2_release)
    );

    pcl_stretch #(.HOLD(PCL_HOLD_CYC)) u_pcl (
        .clk(clk), .rst_n(rst_n), .pcl_i(pcl_in), .active_o(pcl_active)
    );

    // Next-state selection; a supply drop overrides everything.
    always_comb begin
        state_d = state_q;
        if (vcc_below_off) begin
            state_d = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:  if (vcc_above_on) state_d = fb_ok ? ST_SOFT : ST_STBY;
                ST_STBY: if (fb_ok) state_d = ST_SOFT;
                ST_SOFT: begin
                    if (!fb_ok)           state_d = ST_STBY;
                    else if (ov2_release) state_d = ST_SOFT;
                    else if (fb_near)     state_d = ST_RUN;
                end
                ST_RUN: begin
                    if (!fb_ok)           state_d = ST_STBY;
                    else if (ov2_release) state_d = ST_SOFT;
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Priority encoding of the most urgent active condition.
    always_comb begin
        if (state_q == ST_OFF)         code = FC_UVLO;
        else if (state_q == ST_STBY)   code = FC_OPEN;
        else if (ov1_trip && ov2_trip) code = FC_OV_BOTH;
        else if (ov2_trip)             code = FC_OV2;
        else if (ov1_trip)             code = FC_OV1;
        else                           code = FC_NONE;
    end

    assign run_en     = (state_q == ST_SOFT || state_q == ST_RUN) && !ov1_trip && !ov2_trip;
    assign soft_start = (state_q == ST_SOFT);
    assign standby    = (state_q == ST_STBY);
    assign gate_off   = !run_en || pcl_active;
    assign fault_code = code;
endmodule

// File: rtl/pfc_supervisor_chk.sv
// Property checker for pfc_supervisor, bound to every instance of it.
module pfc_supervisor_chk
    import pfc_sup_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       vcc_below_off,
    input logic       fb_ok,
    input logic       fb_near,
    input logic       ov1_set,
    input logic       pcl_in,
    input logic       run_en,
    input logic       soft_start,
    input logic       standby,
    input logic       gate_off,
    input logic [2:0] fault_code,
    input logic       ov1_trip,
    input logic       ov2_trip,
    input logic       ov2_release,
    input sup_state_t state_q
);
    a_r10_uvlo_override: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_below_off |=> (fault_code == 3'd1 && !run_en && gate_off));

    a_r3_standby_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({standby, run_en}));

    a_r6_ov1_gates: assert property (@(posedge clk) disable iff (!rst_n)
        ov1_trip |-> (gate_off && !run_en));

    a_r8_both_code: assert property (@(posedge clk) disable iff (!rst_n)
        (ov1_trip && ov2_trip && (state_q == ST_SOFT || state_q == ST_RUN)) |-> fault_code == 3'd3);

    a_r9_pcl_gate: assert property (@(posedge clk) disable iff (!rst_n)
        pcl_in |=> gate_off);

    a_r5_ov1_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ov1_trip) |-> $past(ov1_set));

    a_r7_ov2_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (ov2_release && fb_ok && !vcc_below_off && (state_q == ST_RUN || state_q == ST_SOFT))
        |=> soft_start);

    a_r4_soft_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SOFT && fb_ok && fb_near && !ov2_release && !vcc_below_off)
        |=> !soft_start);
endmodule

bind pfc_supervisor pfc_supervisor_chk u_chk (.*);

// File: tb/tb_pfc_supervisor.sv
// Directed sweep bench for pfc_supervisor with short blanking and hold counts.
module tb_pfc_supervisor;
    localparam int CLK_PERIOD = 10;
    localparam int B1 = 4;
    localparam int B2 = 6;
    localparam int H  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_above_on = 0, vcc_below_off = 0, fb_ok = 0, fb_near = 0;
    logic ov1_set = 0, ov1_clr = 0, ov2_set = 0, ov2_clr = 0, pcl_in = 0;
    logic run_en, soft_start, standby, gate_off;
    logic [2:0] fault_code;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pfc_supervisor #(.OV1_BLANK_CYC(B1), .OV2_BLANK_CYC(B2), .PCL_HOLD_CYC(H)) dut (
        .clk(clk), .rst_n(rst_n),
        .vcc_above_on(vcc_above_on), .vcc_below_off(vcc_below_off),
        .fb_ok(fb_ok), .fb_near(fb_near),
        .ov1_set(ov1_set), .ov1_clr(ov1_clr),
        .ov2_set(ov2_set), .ov2_clr(ov2_clr),
        .pcl_in(pcl_in),
        .run_en(run_en), .soft_start(soft_start), .standby(standby),
        .gate_off(gate_off), .fault_code(fault_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Full output vector: run_en, soft_start, standby, gate_off, fault_code.
    task automatic chk_all(input string req, input int r, input int s, input int sb,
                           input int g, input int fc);
        chk({req, " run_en"}, int'(run_en), r);
        chk({req, " soft_start"}, int'(soft_start), s);
        chk({req, " standby"}, int'(standby), sb);
        chk({req, " gate_off"}, int'(gate_off), g);
        chk({req, " fault_code"}, int'(fault_code), fc);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        chk_all("R1 reset", 0, 0, 0, 1, 1);

        // R1: between levels stays off
        step(2);
        chk_all("R1 hold off", 0, 0, 0, 1, 1);

        // R2: start with low sense goes to standby; R1 hysteresis keeps it on
        vcc_above_on = 1;
        step(1);
        chk_all("R2 standby entry", 0, 0, 1, 1, 2);
        vcc_above_on = 0;
        step(2);
        chk_all("R1 hysteresis", 0, 0, 1, 1, 2);

        // R3/R2: sense recovers -> soft-start
        fb_ok = 1;
        step(1);
        chk_all("R3 soft restart", 1, 1, 0, 0, 0);

        // R4: near regulation releases soft-start
        fb_near = 1;
        step(1);
        chk_all("R4 soft release", 1, 0, 0, 0, 0);

        // R5/R6: first over-voltage blanking sweep
        for (int len = 1; len <= B1 + 1; len++) begin
            ov1_set = 1;
            step(len);
            chk("R5 ov1 blank code", int'(fault_code), (len >= B1) ? 5 : 0);
            chk("R6 ov1 gate", int'(gate_off), (len >= B1) ? 1 : 0);
            ov1_set = 0;
            if (len >= B1) begin
                ov1_clr = 1;
                step(1);
                ov1_clr = 0;
                chk_all("R6 ov1 release", 1, 0, 0, 0, 0);
            end else begin
                step(1);
                chk("R5 gap restarts", int'(fault_code), 0);
            end
        end

        // R5: interrupted run never trips
        ov1_set = 1; step(B1 - 1);
        ov1_set = 0; step(1);
        ov1_set = 1; step(B1 - 1);
        chk("R5 interrupted", int'(fault_code), 0);
        ov1_set = 0; step(1);

        // R7: second over-voltage blanking sweep and soft restart on release
        for (int len = 1; len <= B2 + 1; len++) begin
            ov2_set = 1;
            step(len);
            chk("R7 ov2 blank code", int'(fault_code), (len >= B2) ? 4 : 0);
            chk("R7 ov2 gate", int'(gate_off), (len >= B2) ? 1 : 0);
            ov2_set = 0;
            if (len >= B2) begin
                ov2_clr = 1;
                fb_near = 0;
                step(1);
                ov2_clr = 0;
                chk_all("R7 ov2 release", 1, 1, 0, 0, 0);
                fb_near = 1;
                step(1);
                chk("R4 after restart", int'(soft_start), 0);
            end else begin
                step(1);
                chk("R7 gap restarts", int'(fault_code), 0);
            end
        end

        // R8: both tripped, first path released first
        ov1_set = 1; ov2_set = 1;
        step(B1);
        chk("R11 ov1 only", int'(fault_code), 5);
        step(B2 - B1);
        chk("R8 both code", int'(fault_code), 3);
        ov1_set = 0; ov2_set = 0;
        ov1_clr = 1;
        step(1);
        ov1_clr = 0;
        chk("R8 ov2 remains", int'(fault_code), 4);
        chk("R8 gate held", int'(gate_off), 1);
        ov2_clr = 1; fb_near = 0;
        step(1);
        ov2_clr = 0;
        chk_all("R8 both clear", 1, 1, 0, 0, 0);
        fb_near = 1; step(1);

        // R8: both tripped, second path released first
        ov1_set = 1; ov2_set = 1;
        step(B2);
        ov1_set = 0; ov2_set = 0;
        ov2_clr = 1; fb_near = 0;
        step(1);
        ov2_clr = 0;
        chk("R8 ov1 remains", int'(fault_code), 5);
        chk("R8 gate held 2", int'(gate_off), 1);
        chk("R7 soft during ov1", int'(soft_start), 1);
        ov1_clr = 1;
        step(1);
        ov1_clr = 0;
        chk_all("R8 both clear 2", 1, 1, 0, 0, 0);
        fb_near = 1; step(1);

        // R9: peak-current stretch
        pcl_in = 1;
        step(1);
        pcl_in = 0;
        chk_all("R9 pcl active", 1, 0, 0, 1, 0);
        for (int k = 1; k <= H; k++) begin
            step(1);
            chk("R9 pcl stretch", int'(gate_off), (k < H) ? 1 : 0);
            chk("R9 state kept", int'(run_en), 1);
        end

        // R3: open loop from run
        fb_ok = 0;
        step(1);
        chk_all("R3 open loop", 0, 0, 1, 1, 2);
        fb_ok = 1; fb_near = 0;
        step(1);
        chk_all("R3 restart", 1, 1, 0, 0, 0);

        // R10: supply drop overrides a tripped path and clears it
        ov1_set = 1;
        step(B1);
        chk("R6 ov1 in soft", int'(fault_code), 5);
        ov1_set = 0; vcc_below_off = 1;
        step(1);
        chk_all("R10 uvlo override", 0, 0, 0, 1, 1);
        vcc_below_off = 0;
        step(2);
        chk("R1 off until on", int'(fault_code), 1);
        vcc_above_on = 1;
        step(1);
        vcc_above_on = 0;
        chk_all("R10 trips cleared", 1, 1, 0, 0, 0);

        // R10: supply drop from standby
        fb_ok = 0; step(1);
        vcc_below_off = 1; step(1);
        chk("R10 from standby", int'(fault_code), 1);
        vcc_below_off = 0; step(1);

        summary();
    end
endmodule